// File: doc/BRIEF.md
# Multi-Mode Event and Quadrature Counter

This block is one counter channel with a 32-bit count. It watches three asynchronous signals: phase A, phase B and an index line. Each signal is first brought into the system clock domain, and then its edges are found. The count can run in one of three ways. It can total the edges of phase A. It can count phase A edges up or down, with the direction taken from the level of phase B. It can also decode a quadrature encoder at 1X, 2X or 4X resolution. A rising edge on the index line can do one of four things to the count: clear it, gate it, latch it or decrement it. The index action is chosen by configuration.

Software reads the count through a one-beat request and response stream. A single-cycle `rd_req` strobe is always accepted. One cycle later, `rd_valid` comes with `rd_data`, which holds the count as it stood before any event in the request cycle. There is no back-pressure on either side: a request is never stalled, and the response is valid for exactly one cycle, so the consumer must take it then. When clear-on-read is enabled, the same request also restarts the counter. An event that arrives in the request cycle is not lost: it becomes the first contribution to the new count.

Top module: `qcnt_channel`

## Requirements
- R1: With `cfg_mode`=0 (totalize), each selected phase A edge adds one (`cfg_a_fall`=0 selects rising, 1 selects falling). Phase B has no effect.
- R2: With `cfg_mode`=1 (up/down), each selected phase A edge counts up when the synchronized phase B level equals `cfg_b_up_lvl`, and counts down otherwise.
- R3: With `cfg_mode`=2 (encoder) and `cfg_res`=0 (1X), only the selected phase A edge counts. Sequence {A,B} 00→10→11→01→00 counts up, and its reverse counts down.
- R4: Encoder 2X (`cfg_res`=1) counts both edges of phase A, which gives two counts per quadrature cycle.
- R5: Encoder 4X (`cfg_res`=2) counts every edge of A and of B, which gives four counts per quadrature cycle.
- R6: In encoder mode, a sample where A and B both change is ignored.
- R7: With `cfg_idx_act`=1 (clear), an index rising edge sets the count to that cycle's event contribution, which is 0 when there is no event.
- R8: With `cfg_idx_act`=2 (gate), events count only while the synchronized index is high.
- R9: With `cfg_idx_act`=3 (latch), an index rising edge copies the count into `cap_data`, and `cap_valid` goes high for one cycle. The count itself is unchanged.
- R10: With `cfg_idx_act`=4 (decrement), each index rising edge subtracts one.
- R11: A `rd_req` strobe gives `rd_valid`=1 on the next cycle, with `rd_data` equal to the count before that cycle's event. With clear-on-read off, the count is unaffected.
- R12: With `cfg_clr_on_read`=1, a read also restarts the count at that cycle's event contribution.
- R13: The count wraps modulo 2^32 in both directions.
- R14: An input change set up before clock edge k shows on `cnt_value` after edge k+2, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_mode | input | 2 | 0 totalize, 1 up/down, 2 encoder, 3 no counting |
| cfg_res | input | 2 | Encoder resolution: 0 1X, 1 2X, 2 4X, 3 no counting |
| cfg_a_fall | input | 1 | Selected phase A edge: 0 rising, 1 falling |
| cfg_b_up_lvl | input | 1 | Phase B level that means count up in up/down mode |
| cfg_idx_act | input | 3 | Index action: 0 none, 1 clear, 2 gate, 3 latch, 4 decrement |
| cfg_clr_on_read | input | 1 | Clear the counter on each read |
| a_in | input | 1 | Phase A, asynchronous |
| b_in | input | 1 | Phase B, asynchronous |
| idx_in | input | 1 | Index, asynchronous |
| rd_req | input | 1 | Read request strobe, always accepted |
| rd_valid | output | 1 | Read response valid, one cycle |
| rd_data | output | 32 | Read response value |
| cap_valid | output | 1 | Index latch pulse |
| cap_data | output | 32 | Value captured on the index edge |
| cnt_value | output | 32 | Live count |

## Verification
`cnt_value` is updated on every clock edge, so an error in the edge history or in the direction decode shows up there two edges after the input change. Such an error usually stays visible as a lasting offset in the count. A fault in the read or capture registers shows up on `rd_data` or `cap_data` one cycle after the strobe or index edge. The sweeps compare each count against counts worked out arithmetically in the bench, for every mode, resolution and direction. Cases that fall in the same cycle as another event are driven on purpose, so that a dropped or doubled event leaves the count off by one.

// File: rtl/qcnt_pkg.sv
`timescale 1ns/1ps
package qcnt_pkg;
  typedef enum logic [1:0] {
    MODE_TOTAL = 2'd0,
    MODE_UPDN  = 2'd1,
    MODE_ENC   = 2'd2,
    MODE_OFF   = 2'd3
  } mode_e;

  typedef enum logic [1:0] {
    RES_X1  = 2'd0,
    RES_X2  = 2'd1,
    RES_X4  = 2'd2,
    RES_OFF = 2'd3
  } res_e;

  localparam logic [2:0] IDX_NONE  = 3'd0;
  localparam logic [2:0] IDX_CLEAR = 3'd1;
  localparam logic [2:0] IDX_GATE  = 3'd2;
  localparam logic [2:0] IDX_LATCH = 3'd3;
  localparam logic [2:0] IDX_DEC   = 3'd4;
endpackage

// File: rtl/qcnt_sync.sv
`timescale 1ns/1ps
module qcnt_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stg <= '0;
    end else begin
      stg[0] <= din;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign dout = stg[LAST];

  // First stage follows the pin one edge later (latency part of R14)
  p_first_stage_r14: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> stg[0] == $past(din));
endmodule

// File: rtl/qcnt_edge_decode.sv
`timescale 1ns/1ps
module qcnt_edge_decode
  import qcnt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sa,
  input  logic       sb,
  input  logic       sidx,
  input  mode_e      mode,
  input  res_e       res,
  input  logic       a_fall_sel,
  input  logic       b_up_lvl,
  output logic       step_up,
  output logic       step_dn,
  output logic       idx_rise,
  output logic       idx_lvl
);
  logic pa, pb, pidx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pa   <= 1'b0;
      pb   <= 1'b0;
      pidx <= 1'b0;
    end else begin
      pa   <= sa;
      pb   <= sb;
      pidx <= sidx;
    end
  end

  logic a_chg, b_chg, a_sel, quad_ok, a_fwd, b_fwd;

  always_comb begin
    a_chg   = sa ^ pa;
    b_chg   = sb ^ pb;
    a_sel   = a_chg & (a_fall_sel ? ~sa : sa);
    quad_ok = ~(a_chg & b_chg);
    a_fwd   = sa ^ sb;
    b_fwd   = ~(sa ^ sb);
  end

  always_comb begin
    step_up = 1'b0;
    step_dn = 1'b0;
    unique case (mode)
      MODE_TOTAL: step_up = a_sel;
      MODE_UPDN: begin
        step_up = a_sel & (sb == b_up_lvl);
        step_dn = a_sel & (sb != b_up_lvl);
      end
      MODE_ENC: begin
        if (quad_ok) begin
          unique case (res)
            RES_X1: begin
              step_up = a_sel & a_fwd;
              step_dn = a_sel & ~a_fwd;
            end
            RES_X2: begin
              step_up = a_chg & a_fwd;
              step_dn = a_chg & ~a_fwd;
            end
            RES_X4: begin
              step_up = (a_chg & a_fwd) | (b_chg & b_fwd);
              step_dn = (a_chg & ~a_fwd) | (b_chg & ~b_fwd);
            end
            default: ;
          endcase
        end
      end
      default: ;
    endcase
  end

  assign idx_rise = sidx & ~pidx;
  assign idx_lvl  = sidx;

  p_total_up_only_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_TOTAL) |-> !step_dn);

  p_updn_dir_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_UPDN && (step_up || step_dn)) |-> (step_up == (sb == b_up_lvl)));

  p_x1_b_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_ENC && res == RES_X1 && $stable(sa)) |-> !(step_up || step_dn));

  p_x4_every_edge_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_ENC && res == RES_X4 && $past(rst_n) &&
     ((sa != $past(sa)) != (sb != $past(sb)))) |-> (step_up || step_dn));

  p_invalid_skip_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_ENC && $past(rst_n) && sa != $past(sa) && sb != $past(sb))
      |-> !(step_up || step_dn));

  p_single_step_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !(step_up && step_dn));
endmodule

// File: rtl/qcnt_accum.sv
`timescale 1ns/1ps
module qcnt_accum
  import qcnt_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_up,
  input  logic             step_dn,
  input  logic             idx_rise,
  input  logic             idx_lvl,
  input  logic [2:0]       idx_act,
  input  logic             clr_on_read,
  input  logic             rd_req,
  output logic             rd_valid,
  output logic [CNT_W-1:0] rd_data,
  output logic             cap_valid,
  output logic [CNT_W-1:0] cap_data,
  output logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic             gate_ok, up_q, dn_q, dec_evt, clr_evt, cap_evt;
  logic [CNT_W-1:0] delta, base, count_nxt;

  always_comb begin
    gate_ok   = (idx_act != IDX_GATE) || idx_lvl;
    up_q      = step_up & gate_ok;
    dn_q      = step_dn & gate_ok;
    dec_evt   = (idx_act == IDX_DEC) & idx_rise;
    cap_evt   = (idx_act == IDX_LATCH) & idx_rise;
    clr_evt   = ((idx_act == IDX_CLEAR) & idx_rise) | (rd_req & clr_on_read);
    delta     = up_q ? ONE : (dn_q ? '1 : '0);
    base      = clr_evt ? '0 : count;
    count_nxt = base + delta - (dec_evt ? ONE : '0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count     <= '0;
      rd_valid  <= 1'b0;
      rd_data   <= '0;
      cap_valid <= 1'b0;
      cap_data  <= '0;
    end else begin
      count     <= count_nxt;
      rd_valid  <= rd_req;
      cap_valid <= cap_evt;
      if (rd_req)  rd_data  <= count;
      if (cap_evt) cap_data <= count;
    end
  end

  p_clear_idx_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (idx_act == IDX_CLEAR && idx_rise && !step_up && !step_dn) |=> count == '0);

  p_gate_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (idx_act == IDX_GATE && !idx_lvl && !(rd_req && clr_on_read)) |=> $stable(count));

  p_latch_copy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (idx_act == IDX_LATCH && idx_rise) |=> (cap_valid && cap_data == $past(count)));

  p_dec_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (idx_act == IDX_DEC && idx_rise && !step_up && !step_dn && !(rd_req && clr_on_read))
      |=> count == $past(count) - ONE);

  p_read_return_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> (rd_valid && rd_data == $past(count)));

  p_read_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> !rd_valid);

  p_read_clear_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && clr_on_read && !step_up && !step_dn && !idx_rise) |=> count == '0);
endmodule

// File: rtl/qcnt_channel.sv
`timescale 1ns/1ps
module qcnt_channel
  import qcnt_pkg::*;
#(
  parameter int CNT_W       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       cfg_mode,
  input  logic [1:0]       cfg_res,
  input  logic             cfg_a_fall,
  input  logic             cfg_b_up_lvl,
  input  logic [2:0]       cfg_idx_act,
  input  logic             cfg_clr_on_read,
  input  logic             a_in,
  input  logic             b_in,
  input  logic             idx_in,
  input  logic             rd_req,
  output logic             rd_valid,
  output logic [CNT_W-1:0] rd_data,
  output logic             cap_valid,
  output logic [CNT_W-1:0] cap_data,
  output logic [CNT_W-1:0] cnt_value
);
  localparam int PIN_W = 3;

  logic [PIN_W-1:0] pins_raw, pins_s;
  logic             step_up, step_dn, idx_rise, idx_lvl;

  assign pins_raw = {idx_in, b_in, a_in};

  qcnt_sync #(.W(PIN_W), .STAGES(SYNC_STAGES)) sync_i (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (pins_raw),
    .dout (pins_s)
  );

  qcnt_edge_decode dec_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .sa        (pins_s[0]),
    .sb        (pins_s[1]),
    .sidx      (pins_s[2]),
    .mode      (mode_e'(cfg_mode)),
    .res       (res_e'(cfg_res)),
    .a_fall_sel(cfg_a_fall),
    .b_up_lvl  (cfg_b_up_lvl),
    .step_up   (step_up),
    .step_dn   (step_dn),
    .idx_rise  (idx_rise),
    .idx_lvl   (idx_lvl)
  );

  qcnt_accum #(.CNT_W(CNT_W)) acc_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .step_up    (step_up),
    .step_dn    (step_dn),
    .idx_rise   (idx_rise),
    .idx_lvl    (idx_lvl),
    .idx_act    (cfg_idx_act),
    .clr_on_read(cfg_clr_on_read),
    .rd_req     (rd_req),
    .rd_valid   (rd_valid),
    .rd_data    (rd_data),
    .cap_valid  (cap_valid),
    .cap_data   (cap_data),
    .count      (cnt_value)
  );
endmodule

// File: tb/qcnt_channel_tb_top.sv
`timescale 1ns/1ps
module qcnt_channel_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  cfg_mode = 2'd0;
  logic [1:0]  cfg_res = 2'd0;
  logic        cfg_a_fall = 1'b0;
  logic        cfg_b_up_lvl = 1'b1;
  logic [2:0]  cfg_idx_act = 3'd0;
  logic        cfg_clr_on_read = 1'b0;
  logic        a_in = 1'b0;
  logic        b_in = 1'b0;
  logic        idx_in = 1'b0;
  logic        rd_req = 1'b0;
  logic        rd_valid, cap_valid;
  logic [31:0] rd_data, cap_data, cnt_value;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  qcnt_channel dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_res(cfg_res),
    .cfg_a_fall(cfg_a_fall), .cfg_b_up_lvl(cfg_b_up_lvl), .cfg_idx_act(cfg_idx_act),
    .cfg_clr_on_read(cfg_clr_on_read), .a_in(a_in), .b_in(b_in), .idx_in(idx_in),
    .rd_req(rd_req), .rd_valid(rd_valid), .rd_data(rd_data), .cap_valid(cap_valid),
    .cap_data(cap_data), .cnt_value(cnt_value)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (5) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; a_in = 1'b0; b_in = 1'b0; idx_in = 1'b0; rd_req = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    settle();
  endtask

  task automatic set_ab(input logic a, input logic b);
    a_in = a; b_in = b;
    settle();
  endtask

  task automatic set_idx(input logic v);
    idx_in = v;
    settle();
  endtask

  task automatic a_pulse();
    set_ab(1'b1, b_in);
    set_ab(1'b0, b_in);
  endtask

  task automatic do_read(input string req, input logic [31:0] exp_data);
    rd_req = 1'b1;
    @(negedge clk);
    rd_req = 1'b0;
    chk(req, {31'd0, rd_valid}, 32'd1);
    chk(req, rd_data, exp_data);
    @(negedge clk);
    chk(req, {31'd0, rd_valid}, 32'd0);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    logic [1:0] fwd [4];
    fwd[0] = 2'b00; fwd[1] = 2'b10; fwd[2] = 2'b11; fwd[3] = 2'b01;

    do_reset();
    chk("reset", cnt_value, 32'd0);
    chk("reset", {30'd0, rd_valid, cap_valid}, 32'd0);

    // R1: totalize, both edge selects; B toggles and must not matter
    for (int fe = 0; fe < 2; fe++) begin
      cfg_mode = 2'd0; cfg_a_fall = fe[0];
      do_reset();
      for (int p = 1; p <= 4; p++) begin
        set_ab(1'b1, ~b_in);
        chk("R1 after rise", cnt_value, (fe == 0) ? 32'(p) : 32'(p - 1));
        set_ab(1'b0, ~b_in);
        chk("R1 after fall", cnt_value, 32'(p));
      end
    end

    // R14: count changes after the third edge, not the second
    cfg_mode = 2'd0; cfg_a_fall = 1'b0;
    do_reset();
    a_in = 1'b1;
    @(negedge clk); @(negedge clk);
    chk("R14 not yet", cnt_value, 32'd0);
    @(negedge clk);
    chk("R14 updated", cnt_value, 32'd1);
    settle(); set_ab(1'b0, 1'b0);

    // R2 / R13: up/down with every polarity and B level
    for (int pol = 0; pol < 2; pol++) begin
      for (int bl = 0; bl < 2; bl++) begin
        cfg_mode = 2'd1; cfg_a_fall = 1'b0; cfg_b_up_lvl = pol[0];
        do_reset();
        set_ab(1'b0, bl[0]);
        repeat (3) a_pulse();
        chk("R2 R13 updown", cnt_value, (pol == bl) ? 32'd3 : 32'hFFFF_FFFD);
      end
    end

    // R3 R4 R5: encoder resolutions, directions, edge selects
    for (int res = 0; res < 3; res++) begin
      for (int fe = 0; fe < 2; fe++) begin
        for (int dir = 0; dir < 2; dir++) begin
          cfg_mode = 2'd2; cfg_res = res[1:0]; cfg_a_fall = fe[0];
          do_reset();
          for (int c = 0; c < 3; c++) begin
            for (int s = 1; s <= 4; s++) begin
              logic [1:0] ab;
              ab = (dir == 0) ? fwd[s % 4] : fwd[(4 - s) % 4];
              set_ab(ab[1], ab[0]);
            end
          end
          chk((res == 0) ? "R3 enc x1" : (res == 1) ? "R4 enc x2" : "R5 enc x4",
              cnt_value, (dir == 0) ? 32'(3 * (1 << res)) : 32'(0) - 32'(3 * (1 << res)));
        end
      end
    end

    // R6: simultaneous change of A and B is skipped
    cfg_mode = 2'd2; cfg_res = 2'd2; cfg_a_fall = 1'b0;
    do_reset();
    set_ab(1'b1, 1'b1);
    chk("R6 invalid jump", cnt_value, 32'd0);
    set_ab(1'b0, 1'b1);
    chk("R6 next valid", cnt_value, 32'd1);

    // R7: index clear, including same-cycle event
    cfg_mode = 2'd0; cfg_a_fall = 1'b0; cfg_idx_act = 3'd1;
    do_reset();
    repeat (3) a_pulse();
    chk("R7 before clear", cnt_value, 32'd3);
    set_idx(1'b1);
    chk("R7 clear", cnt_value, 32'd0);
    set_idx(1'b0);
    a_pulse();
    a_in = 1'b1; idx_in = 1'b1;
    settle();
    chk("R7 clear with event", cnt_value, 32'd1);
    set_ab(1'b0, 1'b0); set_idx(1'b0);

    // R8: gate by index level
    cfg_idx_act = 3'd2;
    do_reset();
    repeat (2) a_pulse();
    chk("R8 gated off", cnt_value, 32'd0);
    set_idx(1'b1);
    repeat (2) a_pulse();
    chk("R8 gated on", cnt_value, 32'd2);

    // R9: latch on index edge
    cfg_idx_act = 3'd3;
    do_reset();
    repeat (3) a_pulse();
    idx_in = 1'b1;
    repeat (3) @(negedge clk);
    chk("R9 cap_valid", {31'd0, cap_valid}, 32'd1);
    chk("R9 cap_data", cap_data, 32'd3);
    @(negedge clk);
    chk("R9 cap_valid drop", {31'd0, cap_valid}, 32'd0);
    a_pulse();
    chk("R9 count kept", cnt_value, 32'd4);
    chk("R9 cap held", cap_data, 32'd3);
    set_idx(1'b0);

    // R10 R13: decrement through zero and back up
    cfg_idx_act = 3'd4;
    do_reset();
    set_idx(1'b1);
    chk("R10 R13 dec wrap", cnt_value, 32'hFFFF_FFFF);
    set_idx(1'b0); set_idx(1'b1);
    chk("R10 second dec", cnt_value, 32'hFFFF_FFFE);
    repeat (2) a_pulse();
    chk("R13 wrap up", cnt_value, 32'd0);
    set_idx(1'b0);

    // R11: read without clear
    cfg_idx_act = 3'd0; cfg_clr_on_read = 1'b0;
    do_reset();
    repeat (3) a_pulse();
    do_read("R11 read", 32'd3);
    chk("R11 count kept", cnt_value, 32'd3);

    // R12: clear on read, plain and with a same-cycle event
    cfg_clr_on_read = 1'b1;
    do_read("R12 read", 32'd3);
    chk("R12 cleared", cnt_value, 32'd0);
    repeat (2) a_pulse();
    a_in = 1'b1;
    @(negedge clk); @(negedge clk);
    rd_req = 1'b1;
    @(negedge clk);
    rd_req = 1'b0;
    chk("R12 read with event", rd_data, 32'd2);
    chk("R12 event kept", cnt_value, 32'd1);
    settle();

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule